// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block accepts writes to a software-interrupt trigger register, works out which CPUs the write addresses, and marks the chosen interrupt number pending on each of them. It also remembers which CPU asked for the interrupt. For every target CPU and every interrupt number it keeps a bitmap of the requesting source CPUs. Reads of the trigger register always return zero.

A separate drain step hands these requests to list-register storage that sits outside this block. Software starts a drain for one (target CPU, interrupt number) pair. The sequencer then offers one queue request per remaining source, lowest source number first, and waits for an accept or reject reply to each. Accepted sources leave the bitmap and rejected ones stay. When the drain ends, the block reports completion. If the bitmap is empty at that point, the pending bit is released. If any source is left, the block keeps the pending bit and flags an overflow, which tells the caller to retry later.

Top module: `sgi_dispatch`

## Requirements
- R1: A trigger write is decoded from three fields: bits 3:0 carry the interrupt number, bits 23:16 the CPU target list (bit n means CPU n), and bits 25:24 the filter mode.
- R2: In filter mode 0 the target list is used as written. A write with an empty list changes no pending bit and no source bitmap.
- R3: In filter mode 1 the targets are every online CPU except the writer.
- R4: In filter mode 2 the only target is the writer.
- R5: A write in filter mode 3 is ignored and has no side effect.
- R6: Whatever the filter mode, a CPU whose number is equal to or greater than `online_cnt` is removed from the targets.
- R7: For each target, a write sets that CPU's pending bit for the interrupt number (output `pend_o` bit target*NUM_ID+id) and ORs the writer's one-hot bit into that CPU's source bitmap for the number.
- R8: A drain issues one queue request at a time, with a 3-bit source number. Sources are offered in ascending order, each once per drain, and a request holds steady until a reply arrives.
- R9: An accepted source is removed from the bitmap. A rejected source stays and is offered again by a later drain.
- R10: When no untried source is left, the drain pulses `drain_done`. If the bitmap is then empty, the pending bit is cleared and `drain_ovf` is low. Otherwise `drain_ovf` is high and the pending bit stays set.
- R11: If a trigger write adds a source in the same cycle that an accept removes that same source, the write wins: the bit and the pending bit remain.
- R12: `rd_data`, the read value of the trigger register, is always zero.
- R13: After reset no interrupt is pending, no queue request is issued and no drain is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| online_cnt | input | CNT_W (4) | Number of online CPUs |
| wr_en | input | 1 | Trigger register write strobe |
| wr_cpu | input | SRC_W (3) | Number of the writing CPU |
| wr_data | input | 32 | Trigger register write data |
| rd_data | output | 32 | Trigger register read data (zero) |
| drain_start | input | 1 | Start a drain for one target/number pair |
| drain_cpu | input | SRC_W (3) | Target CPU to drain |
| drain_id | input | ID_W (4) | Interrupt number to drain |
| drain_busy | output | 1 | Drain in progress |
| drain_done | output | 1 | One-cycle pulse at drain end |
| drain_ovf | output | 1 | Sources left at drain end (valid with drain_done) |
| q_req_valid | output | 1 | Queue request offered |
| q_req_cpu | output | SRC_W (3) | Target CPU of the request |
| q_req_id | output | ID_W (4) | Interrupt number of the request |
| q_req_src | output | SRC_W (3) | Source CPU of the request |
| q_rsp_valid | input | 1 | Reply to the current request |
| q_rsp_accept | input | 1 | Reply is accept (1) or reject (0) |
| pend_o | output | NUM_CPU*NUM_ID (128) | Pending bits, index target*NUM_ID+id |

## Verification
A trigger write and a drain's accept can land on the same source bit of the same bitmap cell in the same clock cycle. One edits the cell by an OR and the other by a clear. The bench provokes this on purpose. It starts a drain on a cell with one source and, in the same cycle it returns the accept for that source, issues a write from that source to that target. It then expects the drain to end with overflow, the pending bit still set, and a later drain to deliver the source once more. Random phases keep writes and drains in separate cycles, so the reference model in the bench can stay sequential.

// File: rtl/sgi_pkg.sv
package sgi_pkg;

   // Filter mode field of a trigger write
   typedef enum logic [1:0] {
      FILT_LIST   = 2'd0,
      FILT_OTHERS = 2'd1,
      FILT_SELF   = 2'd2,
      FILT_RSVD   = 2'd3
   } sgi_filt_e;

   // Field positions inside the trigger word
   localparam int unsigned FLD_ID_LSB   = 0;
   localparam int unsigned FLD_ID_W     = 4;
   localparam int unsigned FLD_LIST_LSB = 16;
   localparam int unsigned FLD_LIST_W   = 8;
   localparam int unsigned FLD_MODE_LSB = 24;

   typedef enum logic {
      DRN_IDLE = 1'b0,
      DRN_RUN  = 1'b1
   } drn_state_e;

endpackage

// File: rtl/sgi_decode.sv
module sgi_decode
   import sgi_pkg::*;
#(
   parameter int unsigned NUM_CPU = 8,
   parameter int unsigned NUM_ID  = 16,
   localparam int unsigned SRC_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
   localparam int unsigned ID_W   = $clog2(NUM_ID),
   localparam int unsigned CNT_W  = $clog2(NUM_CPU + 1)
) (
   input  logic               wr_en,
   input  logic [SRC_W-1:0]   wr_cpu,
   input  logic [31:0]        wr_data,
   input  logic [CNT_W-1:0]   online_cnt,
   output logic               set_en,
   output logic [NUM_CPU-1:0] set_tgt,
   output logic [ID_W-1:0]    set_id,
   output logic [NUM_CPU-1:0] set_src
);

   logic [NUM_CPU-1:0]  online_mask;
   logic [NUM_CPU-1:0]  self_oh;
   logic [NUM_CPU-1:0]  raw_tgt;
   logic [NUM_CPU-1:0]  list_f;
   logic [FLD_ID_W-1:0] id_raw;
   logic                id_ok;
   sgi_filt_e           filt;
   logic                unused_wr;

   assign id_raw    = wr_data[FLD_ID_LSB +: FLD_ID_W];
   assign list_f    = wr_data[FLD_LIST_LSB +: NUM_CPU];
   assign filt      = sgi_filt_e'(wr_data[FLD_MODE_LSB +: 2]);
   assign unused_wr = ^wr_data;

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      assign online_mask[c] = (online_cnt > CNT_W'(c));
      assign self_oh[c]     = (wr_cpu == SRC_W'(c));
   end

   // A full-range number field needs no bound check
   if (NUM_ID == (1 << FLD_ID_W)) begin : g_id_full
      assign id_ok = 1'b1;
   end else begin : g_id_part
      assign id_ok = (id_raw < FLD_ID_W'(NUM_ID));
   end

   always_comb begin
      unique case (filt)
         FILT_LIST:   raw_tgt = list_f;
         FILT_OTHERS: raw_tgt = ~self_oh;
         FILT_SELF:   raw_tgt = self_oh;
         default:     raw_tgt = '0;
      endcase
   end

   assign set_tgt = raw_tgt & online_mask;
   assign set_id  = id_raw[ID_W-1:0];
   assign set_src = self_oh;
   assign set_en  = wr_en & id_ok & (|set_tgt);

endmodule

// File: rtl/sgi_src_store.sv
module sgi_src_store #(
   parameter int unsigned NUM_CPU = 8,
   parameter int unsigned NUM_ID  = 16,
   localparam int unsigned SRC_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
   localparam int unsigned ID_W   = $clog2(NUM_ID),
   localparam int unsigned CELLS  = NUM_CPU * NUM_ID
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_en,
   input  logic [NUM_CPU-1:0] set_tgt,
   input  logic [ID_W-1:0]    set_id,
   input  logic [NUM_CPU-1:0] set_src,
   input  logic [SRC_W-1:0]   sel_cpu,
   input  logic [ID_W-1:0]    sel_id,
   input  logic               clr_en,
   input  logic [NUM_CPU-1:0] clr_src,
   input  logic               rel_en,
   output logic [NUM_CPU-1:0] sel_bits,
   output logic [NUM_CPU-1:0] sel_bits_nxt,
   output logic [CELLS-1:0]   pend_flat
);

   logic [NUM_CPU-1:0] src_q [CELLS];
   logic [NUM_CPU-1:0] src_d [CELLS];
   logic [CELLS-1:0]   sel_hit;

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_tgt
      for (genvar i = 0; i < NUM_ID; i++) begin : g_id
         localparam int unsigned K = c * NUM_ID + i;
         logic set_hit;
         assign set_hit    = set_en & set_tgt[c] & (set_id == ID_W'(i));
         assign sel_hit[K] = (sel_cpu == SRC_W'(c)) & (sel_id == ID_W'(i));
         // A new request ORs in after the accept clear: set wins
         assign src_d[K] = (src_q[K] & ~((clr_en & sel_hit[K]) ? clr_src : '0))
                         | (set_hit ? set_src : '0);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               src_q[K]     <= '0;
               pend_flat[K] <= 1'b0;
            end else begin
               src_q[K] <= src_d[K];
               if (set_hit)
                  pend_flat[K] <= 1'b1;
               else if (rel_en && sel_hit[K] && (src_d[K] == '0))
                  pend_flat[K] <= 1'b0;
            end
         end
      end
   end

   always_comb begin
      sel_bits     = '0;
      sel_bits_nxt = '0;
      for (int k = 0; k < CELLS; k++) begin
         if (sel_hit[k]) begin
            sel_bits     = sel_bits | src_q[k];
            sel_bits_nxt = sel_bits_nxt | src_d[k];
         end
      end
   end

endmodule

// File: rtl/sgi_drain.sv
module sgi_drain
   import sgi_pkg::*;
#(
   parameter int unsigned NUM_CPU = 8,
   parameter int unsigned NUM_ID  = 16,
   localparam int unsigned SRC_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
   localparam int unsigned ID_W   = $clog2(NUM_ID)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [SRC_W-1:0]   start_cpu,
   input  logic [ID_W-1:0]    start_id,
   input  logic [NUM_CPU-1:0] live_bits,
   input  logic [NUM_CPU-1:0] live_nxt,
   input  logic               rsp_valid,
   input  logic               rsp_accept,
   output logic               busy,
   output logic [SRC_W-1:0]   sel_cpu,
   output logic [ID_W-1:0]    sel_id,
   output logic               req_valid,
   output logic [SRC_W-1:0]   req_src,
   output logic               clr_en,
   output logic [NUM_CPU-1:0] clr_src,
   output logic               rel_en,
   output logic               done,
   output logic               ovf
);

   drn_state_e         state_q;
   logic [NUM_CPU-1:0] tried_q;
   logic [NUM_CPU-1:0] cand;
   logic [NUM_CPU-1:0] pick_oh;
   logic [SRC_W-1:0]   pick_idx;

   assign cand = live_bits & ~tried_q;

   // Lowest untried source first
   always_comb begin
      pick_idx = '0;
      for (int j = NUM_CPU - 1; j >= 0; j--) begin
         if (cand[j]) pick_idx = SRC_W'(j);
      end
   end
   assign pick_oh = cand & (~cand + NUM_CPU'(1));

   assign busy      = (state_q == DRN_RUN);
   assign req_valid = busy & (|cand);
   assign req_src   = pick_idx;
   assign clr_en    = req_valid & rsp_valid & rsp_accept;
   assign clr_src   = pick_oh;
   assign rel_en    = busy & ~(|cand);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= DRN_IDLE;
         tried_q <= '0;
         sel_cpu <= '0;
         sel_id  <= '0;
         done    <= 1'b0;
         ovf     <= 1'b0;
      end else begin
         done <= 1'b0;
         ovf  <= 1'b0;
         unique case (state_q)
            DRN_IDLE: begin
               if (start) begin
                  state_q <= DRN_RUN;
                  tried_q <= '0;
                  sel_cpu <= start_cpu;
                  sel_id  <= start_id;
               end
            end
            default: begin
               if (|cand) begin
                  if (rsp_valid) tried_q <= tried_q | pick_oh;
               end else begin
                  state_q <= DRN_IDLE;
                  done    <= 1'b1;
                  ovf     <= |live_nxt;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch #(
   parameter int unsigned NUM_CPU = 8,
   parameter int unsigned NUM_ID  = 16,
   localparam int unsigned SRC_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
   localparam int unsigned ID_W   = $clog2(NUM_ID),
   localparam int unsigned CNT_W  = $clog2(NUM_CPU + 1),
   localparam int unsigned CELLS  = NUM_CPU * NUM_ID
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CNT_W-1:0]   online_cnt,
   input  logic               wr_en,
   input  logic [SRC_W-1:0]   wr_cpu,
   input  logic [31:0]        wr_data,
   output logic [31:0]        rd_data,
   input  logic               drain_start,
   input  logic [SRC_W-1:0]   drain_cpu,
   input  logic [ID_W-1:0]    drain_id,
   output logic               drain_busy,
   output logic               drain_done,
   output logic               drain_ovf,
   output logic               q_req_valid,
   output logic [SRC_W-1:0]   q_req_cpu,
   output logic [ID_W-1:0]    q_req_id,
   output logic [SRC_W-1:0]   q_req_src,
   input  logic               q_rsp_valid,
   input  logic               q_rsp_accept,
   output logic [CELLS-1:0]   pend_o
);

   // Elaboration-time parameter checks
   if (NUM_CPU < 2 || NUM_CPU > 8) begin : g_bad_cpu
      $error("sgi_dispatch: NUM_CPU must be 2..8");
   end
   if (NUM_ID < 2 || NUM_ID > 16 || (NUM_ID & (NUM_ID - 1)) != 0) begin : g_bad_id
      $error("sgi_dispatch: NUM_ID must be a power of two in 2..16");
   end

   logic               set_en;
   logic [NUM_CPU-1:0] set_tgt;
   logic [ID_W-1:0]    set_id;
   logic [NUM_CPU-1:0] set_src;
   logic [SRC_W-1:0]   sel_cpu;
   logic [ID_W-1:0]    sel_id;
   logic               clr_en;
   logic [NUM_CPU-1:0] clr_src;
   logic               rel_en;
   logic [NUM_CPU-1:0] sel_bits;
   logic [NUM_CPU-1:0] sel_bits_nxt;

   assign rd_data = '0;

   sgi_decode #(.NUM_CPU(NUM_CPU), .NUM_ID(NUM_ID)) u_decode (
      .wr_en      (wr_en),
      .wr_cpu     (wr_cpu),
      .wr_data    (wr_data),
      .online_cnt (online_cnt),
      .set_en     (set_en),
      .set_tgt    (set_tgt),
      .set_id     (set_id),
      .set_src    (set_src)
   );

   sgi_src_store #(.NUM_CPU(NUM_CPU), .NUM_ID(NUM_ID)) u_store (
      .clk          (clk),
      .rst_n        (rst_n),
      .set_en       (set_en),
      .set_tgt      (set_tgt),
      .set_id       (set_id),
      .set_src      (set_src),
      .sel_cpu      (sel_cpu),
      .sel_id       (sel_id),
      .clr_en       (clr_en),
      .clr_src      (clr_src),
      .rel_en       (rel_en),
      .sel_bits     (sel_bits),
      .sel_bits_nxt (sel_bits_nxt),
      .pend_flat    (pend_o)
   );

   sgi_drain #(.NUM_CPU(NUM_CPU), .NUM_ID(NUM_ID)) u_drain (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (drain_start),
      .start_cpu  (drain_cpu),
      .start_id   (drain_id),
      .live_bits  (sel_bits),
      .live_nxt   (sel_bits_nxt),
      .rsp_valid  (q_rsp_valid),
      .rsp_accept (q_rsp_accept),
      .busy       (drain_busy),
      .sel_cpu    (sel_cpu),
      .sel_id     (sel_id),
      .req_valid  (q_req_valid),
      .req_src    (q_req_src),
      .clr_en     (clr_en),
      .clr_src    (clr_src),
      .rel_en     (rel_en),
      .done       (drain_done),
      .ovf        (drain_ovf)
   );

   assign q_req_cpu = sel_cpu;
   assign q_req_id  = sel_id;

endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk #(
   parameter int unsigned NUM_CPU = 8,
   parameter int unsigned NUM_ID  = 16,
   localparam int unsigned SRC_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
   localparam int unsigned ID_W   = $clog2(NUM_ID),
   localparam int unsigned CNT_W  = $clog2(NUM_CPU + 1),
   localparam int unsigned CELLS  = NUM_CPU * NUM_ID
) (
   input logic               clk,
   input logic               rst_n,
   input logic [CNT_W-1:0]   online_cnt,
   input logic               wr_en,
   input logic [SRC_W-1:0]   wr_cpu,
   input logic [31:0]        wr_data,
   input logic               drain_busy,
   input logic               drain_done,
   input logic               q_req_valid,
   input logic [SRC_W-1:0]   q_req_src,
   input logic               q_rsp_valid,
   input logic [CELLS-1:0]   pend_o
);

   AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      q_req_valid |-> drain_busy);  // R13

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (q_req_valid && !q_rsp_valid) |=> (q_req_valid && $stable(q_req_src)));  // R8

   AST_SRC_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
      (q_req_valid && q_rsp_valid) |=> (!q_req_valid || (q_req_src > $past(q_req_src))));  // R8

   AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      drain_done |-> ($past(drain_busy) && !drain_busy));  // R10

   AST_RSVD_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[25:24] == 2'd3 && !drain_busy) |=> $stable(pend_o));  // R5

   AST_OFFLINE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[25:24] == 2'd2 && CNT_W'(wr_cpu) >= online_cnt && !drain_busy)
      |=> $stable(pend_o));  // R6

   AST_SELF_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[25:24] == 2'd2 && CNT_W'(wr_cpu) < online_cnt
       && int'(wr_data[3:0]) < NUM_ID)
      |=> pend_o[$past(int'(wr_cpu)) * NUM_ID + $past(int'(wr_data[3:0]))]);  // R4

endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NUM_CPU(NUM_CPU), .NUM_ID(NUM_ID)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .online_cnt  (online_cnt),
   .wr_en       (wr_en),
   .wr_cpu      (wr_cpu),
   .wr_data     (wr_data),
   .drain_busy  (drain_busy),
   .drain_done  (drain_done),
   .q_req_valid (q_req_valid),
   .q_req_src   (q_req_src),
   .q_rsp_valid (q_rsp_valid),
   .pend_o      (pend_o)
);

// File: tb/sgi_dispatch_tb.sv
`timescale 1ns/1ps
module sgi_dispatch_tb;

   localparam int NC = 8;
   localparam int NI = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [3:0]   online_cnt = 4'd8;
   logic         wr_en = 1'b0;
   logic [2:0]   wr_cpu = '0;
   logic [31:0]  wr_data = '0;
   logic [31:0]  rd_data;
   logic         drain_start = 1'b0;
   logic [2:0]   drain_cpu = '0;
   logic [3:0]   drain_id = '0;
   logic         drain_busy, drain_done, drain_ovf;
   logic         q_req_valid;
   logic [2:0]   q_req_cpu, q_req_src;
   logic [3:0]   q_req_id;
   logic         q_rsp_valid = 1'b0;
   logic         q_rsp_accept = 1'b0;
   logic [NC*NI-1:0] pend_o;

   int checks = 0;
   int errors = 0;

   logic [7:0] exp_src  [NC][NI];
   logic       exp_pend [NC][NI];

   always #5 clk = ~clk;

   sgi_dispatch #(.NUM_CPU(NC), .NUM_ID(NI)) u_dut (
      .clk(clk), .rst_n(rst_n), .online_cnt(online_cnt),
      .wr_en(wr_en), .wr_cpu(wr_cpu), .wr_data(wr_data), .rd_data(rd_data),
      .drain_start(drain_start), .drain_cpu(drain_cpu), .drain_id(drain_id),
      .drain_busy(drain_busy), .drain_done(drain_done), .drain_ovf(drain_ovf),
      .q_req_valid(q_req_valid), .q_req_cpu(q_req_cpu), .q_req_id(q_req_id),
      .q_req_src(q_req_src), .q_rsp_valid(q_rsp_valid), .q_rsp_accept(q_rsp_accept),
      .pend_o(pend_o)
   );

   task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                      input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] f_targets(input int cpu, input logic [31:0] d,
                                            input int online);
      logic [7:0] t, m;
      m = '0;
      for (int c = 0; c < NC; c++) if (c < online) m[c] = 1'b1;
      case (d[25:24])
         2'd0: t = d[23:16];
         2'd1: t = ~(8'd1 << cpu);
         2'd2: t = 8'd1 << cpu;
         default: t = '0;
      endcase
      return t & m;
   endfunction

   function automatic logic [NC*NI-1:0] f_pend_vec();
      logic [NC*NI-1:0] v;
      for (int c = 0; c < NC; c++)
         for (int i = 0; i < NI; i++) v[c*NI+i] = exp_pend[c][i];
      return v;
   endfunction

   function automatic logic [31:0] f_word(input int mode, input logic [7:0] lst,
                                          input int id);
      return {6'd0, 2'(mode), lst, 12'd0, 4'(id)};
   endfunction

   task automatic model_write(input int cpu, input logic [31:0] d);
      logic [7:0] t;
      t = f_targets(cpu, d, int'(online_cnt));
      for (int c = 0; c < NC; c++) begin
         if (t[c]) begin
            exp_pend[c][d[3:0]] = 1'b1;
            exp_src[c][d[3:0]]  = exp_src[c][d[3:0]] | (8'd1 << cpu);
         end
      end
   endtask

   task automatic do_write(input int cpu, input logic [31:0] d, input string tag);
      @(negedge clk);
      wr_en = 1'b1; wr_cpu = 3'(cpu); wr_data = d;
      model_write(cpu, d);
      @(negedge clk);
      wr_en = 1'b0;
      chk(pend_o == f_pend_vec(), tag, 128'(pend_o), 128'(f_pend_vec()));
   endtask

   task automatic do_drain(input int cpu, input int id, input logic [7:0] acc,
                           input string tag);
      logic [7:0] tried;
      logic [7:0] cand;
      int exp_s;
      bit fin;
      tried = '0;
      fin = 1'b0;
      @(negedge clk);
      drain_start = 1'b1; drain_cpu = 3'(cpu); drain_id = 4'(id);
      @(negedge clk);
      drain_start = 1'b0;
      for (int n = 0; n < 40 && !fin; n++) begin
         if (drain_done) begin
            q_rsp_valid = 1'b0;
            chk(drain_ovf == (exp_src[cpu][id] != 0), {tag, " ovf"},
                128'(drain_ovf), 128'(exp_src[cpu][id] != 0));
            if (exp_src[cpu][id] == 0) exp_pend[cpu][id] = 1'b0;
            chk(pend_o == f_pend_vec(), {tag, " pend"}, 128'(pend_o), 128'(f_pend_vec()));
            fin = 1'b1;
         end else if (q_req_valid) begin
            cand = exp_src[cpu][id] & ~tried;
            exp_s = -1;
            for (int j = NC - 1; j >= 0; j--) if (cand[j]) exp_s = j;
            chk(int'(q_req_src) == exp_s && int'(q_req_cpu) == cpu && int'(q_req_id) == id,
                {tag, " src"}, 128'(q_req_src), 128'(exp_s));
            q_rsp_valid = 1'b1;
            q_rsp_accept = acc[q_req_src];
            tried[q_req_src] = 1'b1;
            if (acc[q_req_src]) exp_src[cpu][id][q_req_src] = 1'b0;
            @(negedge clk);
         end else begin
            q_rsp_valid = 1'b0;
            @(negedge clk);
         end
      end
      q_rsp_valid = 1'b0;
      if (!fin) chk(1'b0, {tag, " done timeout"}, 128'(0), 128'(1));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] w;
      for (int c = 0; c < NC; c++)
         for (int i = 0; i < NI; i++) begin exp_src[c][i] = '0; exp_pend[c][i] = 1'b0; end
      void'($urandom(32'h5eed_0101));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R13 reset state
      chk(pend_o == '0, "R13 pend", 128'(pend_o), 128'(0));
      chk(!q_req_valid && !drain_busy, "R13 idle", 128'({q_req_valid, drain_busy}), 128'(0));
      chk(rd_data == 0, "R12 read", 128'(rd_data), 128'(0));

      // R1 R2 R7 explicit list
      do_write(3, f_word(0, 8'h06, 5), "R2 R7 list");
      do_write(0, f_word(0, 8'h00, 7), "R2 empty list");
      online_cnt = 4'd4;
      do_write(2, f_word(1, 8'h00, 9), "R3 R6 others");
      online_cnt = 4'd8;
      do_write(5, f_word(2, 8'h00, 4), "R4 self");
      do_write(1, f_word(3, 8'hff, 2), "R5 reserved");
      online_cnt = 4'd4;
      do_write(6, f_word(0, 8'hff, 1), "R6 mask list");
      do_write(6, f_word(2, 8'h00, 3), "R6 offline self");
      online_cnt = 4'd8;
      chk(rd_data == 0, "R12 read after writes", 128'(rd_data), 128'(0));

      // R8 R10 single source drained
      do_drain(1, 5, 8'hff, "R8 R10 single");
      // R9 multi source with a reject
      do_write(0, f_word(0, 8'h01, 12), "R7 src0");
      do_write(4, f_word(0, 8'h01, 12), "R7 src4");
      do_write(6, f_word(0, 8'h01, 12), "R7 src6");
      do_drain(0, 12, 8'hef, "R9 R10 reject");
      do_drain(0, 12, 8'hff, "R9 R10 retry");
      do_drain(2, 11, 8'hff, "R10 empty cell");

      // R11 write and accept on the same bit in the same cycle
      do_write(2, f_word(0, 8'h02, 5), "R11 setup");
      @(negedge clk);
      drain_start = 1'b1; drain_cpu = 3'd1; drain_id = 4'd5;
      @(negedge clk);
      drain_start = 1'b0;
      chk(q_req_valid && q_req_src == 3'd2, "R11 req", 128'(q_req_src), 128'(2));
      q_rsp_valid = 1'b1; q_rsp_accept = 1'b1;
      wr_en = 1'b1; wr_cpu = 3'd2; wr_data = f_word(0, 8'h02, 5);
      @(negedge clk);
      q_rsp_valid = 1'b0; wr_en = 1'b0;
      @(negedge clk);
      chk(drain_done && drain_ovf, "R11 ovf", 128'({drain_done, drain_ovf}), 128'(3));
      chk(pend_o[1*NI+5] == 1'b1, "R11 pend kept", 128'(pend_o[1*NI+5]), 128'(1));
      do_drain(1, 5, 8'hff, "R11 redeliver");

      // Constrained random phase
      for (int it = 0; it < 80; it++) begin
         online_cnt = 4'(1 + $urandom % 8);
         w = f_word(int'($urandom % 4), 8'($urandom), int'($urandom % 16));
         do_write(int'($urandom % 8), w, "R1 R7 random write");
         if (it % 3 == 2)
            do_drain(int'($urandom % 8), int'($urandom % 16), 8'($urandom),
                     "R9 R10 random drain");
      end
      chk(rd_data == 0, "R12 read end", 128'(rd_data), 128'(0));

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule